// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps a 64-bit time of day in whole nanoseconds. Each clock cycle in which the run bit is set, it adds a programmable increment in fixed-point form: 32 integer bits of nanoseconds above 32 bits of binary fraction. A 32-bit fraction accumulator carries the sub-nanosecond remainder from cycle to cycle. The nanosecond count therefore tracks clock periods that are not a whole number of nanoseconds, such as 1.6 ns, with no drift beyond one part in 2^32.

Software reaches the time, the increment and the run bit through a plain 32-bit register strobe interface. The 64-bit quantities are split into a low and a high word. Two rules keep word-pair accesses coherent while the counter moves. A low-word time read freezes the high half for the next high-word read. A word pair that is written takes effect only when its high word arrives. A link-speed code input, applied with a one-cycle strobe, loads the matching default increment. The slowest speed code loads zero and stops the clock.

Top module: `tod_frac_counter`

## Requirements
- R1: After reset the time and the fraction are zero, the run bit is 0, and the active increment is 0x0000_0001_9999_9999. The time_ns port always shows the current 64-bit nanosecond count.
- R2: In each cycle with the run bit set and no time load, the fraction adds the low increment word (bits 31:0). The time adds the high increment word (bits 63:32) plus the carry out of the fraction. After N such cycles from a zero time and fraction, time = floor(N * increment / 2^32).
- R3: A read of the low time word (address 0) returns time bits 31:0 and freezes bits 63:32. The next read of the high time word (address 1) returns that frozen half, even if the counter has since carried into it.
- R4: A write to address 0 only stores a pending low word. A write to address 1 loads time = {written word, pending low word} and clears the fraction. This load wins over the advance in the same cycle.
- R5: A write to address 2 stores a pending increment low word and arms a commit. A write to address 3 while armed makes {written word, pending word} the active increment and disarms. A write to address 3 while not armed is ignored.
- R6: speed_load loads a default increment, chosen by speed_code, in the cycle it is sampled. Code 0 (fastest or no link) loads 0x01_9999_9999, code 1 loads 0x03_3333_3333 and code 2 loads 0x20_0000_0000. An armed commit on the same cycle wins.
- R7: speed_code 3 loads an increment of zero, after which the time does not advance even with the run bit set.
- R8: Bit 0 of the control register (address 4) is the run bit. While it is 0, the time changes only by a load through address 1.
- R9: reg_rdata carries the value of a read one cycle after reg_rd is sampled high. Address 2 and address 3 read the active increment low and high words, address 4 reads the run bit, and addresses 5 to 7 read zero.
- R10: After a speed-code load, software can still replace the increment through the address 2 and address 3 pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| speed_code | input | 2 | Link speed code: 0 fastest/no link, 1 middle, 2 slow, 3 unsupported |
| speed_load | input | 1 | Load the default increment for speed_code |
| time_ns | output | 64 | Current nanosecond count |

## Verification
The bench builds the block with its default 32-bit register words and default increment table. With these values, one speed-code load sets a whole-nanosecond increment of 32, and the low time word sits sixteen nanoseconds below its carry into the high word. Three cycles of running then carry into the high half between a low-word read and a high-word read, so the snapshot rule can be checked on exact values. The 1.6 ns default shows the fraction at work: ten cycles give 15 ns, not 16, a value the bench works out from the fixed-point product.

// File: rtl/tod_frac_counter.sv
module tod_frac_counter #(
  parameter int REG_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [2*REG_W-1:0] INC_SPD0 = 64'h0000_0001_9999_9999,
  parameter logic [2*REG_W-1:0] INC_SPD1 = 64'h0000_0003_3333_3333,
  parameter logic [2*REG_W-1:0] INC_SPD2 = 64'h0000_0020_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [1:0]        speed_code,
  input  logic              speed_load,
  output logic [2*REG_W-1:0] time_ns
);
  localparam int TIME_W = 2 * REG_W;
  localparam int INC_W  = 2 * REG_W;
  localparam int FRAC_W = REG_W;
  localparam logic [ADDR_W-1:0] A_TLO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_THI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ILO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IHI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(4);

  logic [TIME_W-1:0] time_q;
  logic [FRAC_W-1:0] frac_q;
  logic [INC_W-1:0]  inc_q;
  logic [REG_W-1:0]  pend_tlo, pend_ilo, snap_hi;
  logic              inc_armed, run_q;
  logic [INC_W-1:0]  speed_inc;

  wire wr_tlo = reg_wr && reg_addr == A_TLO;
  wire wr_thi = reg_wr && reg_addr == A_THI;
  wire wr_ilo = reg_wr && reg_addr == A_ILO;
  wire wr_ihi = reg_wr && reg_addr == A_IHI;
  wire wr_ctl = reg_wr && reg_addr == A_CTL;
  wire rd_tlo = reg_rd && reg_addr == A_TLO;
  wire rd_thi = reg_rd && reg_addr == A_THI;

  wire [REG_W-1:0]  inc_int  = inc_q[INC_W-1:FRAC_W];
  wire [FRAC_W-1:0] inc_frac = inc_q[FRAC_W-1:0];
  wire [FRAC_W:0]   frac_sum = {1'b0, frac_q} + {1'b0, inc_frac};
  wire [TIME_W-1:0] time_next = time_q + TIME_W'(inc_int) + TIME_W'(frac_sum[FRAC_W]);

  assign time_ns = time_q;

  always_comb begin
    case (speed_code)
      2'd0:    speed_inc = INC_SPD0;
      2'd1:    speed_inc = INC_SPD1;
      2'd2:    speed_inc = INC_SPD2;
      default: speed_inc = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      frac_q <= '0;
    end else if (wr_thi) begin
      time_q <= {reg_wdata, pend_tlo};
      frac_q <= '0;
    end else if (run_q) begin
      time_q <= time_next;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tlo  <= '0;
      pend_ilo  <= '0;
      inc_armed <= 1'b0;
      inc_q     <= INC_SPD0;
      run_q     <= 1'b0;
    end else begin
      if (wr_tlo) pend_tlo <= reg_wdata;
      if (wr_ctl) run_q <= reg_wdata[0];
      if (wr_ilo) begin
        pend_ilo  <= reg_wdata;
        inc_armed <= 1'b1;
      end else if (wr_ihi) begin
        inc_armed <= 1'b0;
      end
      if (wr_ihi && inc_armed) inc_q <= {reg_wdata, pend_ilo};
      else if (speed_load)     inc_q <= speed_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      snap_hi   <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_TLO: begin
          reg_rdata <= time_q[REG_W-1:0];
          snap_hi   <= time_q[TIME_W-1:REG_W];
        end
        A_THI:   reg_rdata <= snap_hi;
        A_ILO:   reg_rdata <= inc_frac;
        A_IHI:   reg_rdata <= inc_int;
        A_CTL:   reg_rdata <= REG_W'(run_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R4
  time_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thi |=> time_q == {$past(reg_wdata), $past(pend_tlo)});

  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_thi && $past(rd_tlo)) |=> reg_rdata == $past(time_q[TIME_W-1:REG_W], 2));

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_thi) |=> $stable(time_q));

  // R7
  zero_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == '0 && !wr_thi) |=> $stable(time_q));

  // R5
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ihi && !speed_load) |=> $stable(inc_q));

  // R2
  step_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_thi) |=> (time_q - $past(time_q)) >= TIME_W'($past(inc_int)));

  // R2
  step_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_thi) |=> (time_q - $past(time_q)) <= TIME_W'($past(inc_int)) + TIME_W'(1));
endmodule

// File: tb/tod_frac_counter_test.sv
module tod_frac_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, speed_load = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  speed_code = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_ns;

  int n_run = 0, n_fail = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  tod_frac_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .speed_code(speed_code), .speed_load(speed_load), .time_ns(time_ns)
  );

  always #5 clk = ~clk;

  always @(posedge clk) rd_d <= reg_rd;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: act=%h exp=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_speed(input logic [1:0] c);
    speed_load = 1'b1; speed_code = c;
    @(negedge clk);
    speed_load = 1'b0;
  endtask

  task automatic chk64(input string t, input logic [63:0] act, input logic [63:0] e);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", t, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] e64, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R8 R9 reset state
    chk64("R1 time_ns reset", time_ns, 64'd0);
    rd_chk(3'd0, 32'h0, "R1 time lo reset");
    rd_chk(3'd1, 32'h0, "R1 time hi reset");
    rd_chk(3'd2, 32'h9999_9999, "R1 inc lo reset");
    rd_chk(3'd3, 32'h1, "R1 inc hi reset");
    rd_chk(3'd4, 32'h0, "R8 run bit reset");
    rd_chk(3'd5, 32'h0, "R9 unmapped read");

    // R4 pending low word, load on high write
    wr_reg(3'd0, 32'h1234);
    rd_chk(3'd0, 32'h0, "R4 low write pending");
    wr_reg(3'd1, 32'h5);
    rd_chk(3'd0, 32'h1234, "R4 time lo loaded");
    rd_chk(3'd1, 32'h5, "R4 time hi loaded");

    // R5 increment commit rules
    wr_reg(3'd3, 32'h7);
    rd_chk(3'd3, 32'h1, "R5 unarmed hi ignored");
    wr_reg(3'd2, 32'h5);
    rd_chk(3'd2, 32'h9999_9999, "R5 lo alone not active");
    wr_reg(3'd3, 32'h2);
    rd_chk(3'd2, 32'h5, "R5 commit lo");
    rd_chk(3'd3, 32'h2, "R5 commit hi");
    wr_reg(3'd3, 32'h9);
    rd_chk(3'd3, 32'h2, "R5 disarmed after commit");

    // R6 speed table
    set_speed(2'd1);
    rd_chk(3'd2, 32'h3333_3333, "R6 code1 lo");
    rd_chk(3'd3, 32'h3, "R6 code1 hi");
    set_speed(2'd2);
    rd_chk(3'd2, 32'h0, "R6 code2 lo");
    rd_chk(3'd3, 32'h20, "R6 code2 hi");
    // R10 override after speed load
    wr_reg(3'd2, 32'h10);
    wr_reg(3'd3, 32'h4);
    rd_chk(3'd2, 32'h10, "R10 override lo");
    rd_chk(3'd3, 32'h4, "R10 override hi");
    set_speed(2'd0);
    rd_chk(3'd2, 32'h9999_9999, "R6 code0 lo");
    rd_chk(3'd3, 32'h1, "R6 code0 hi");

    // R2 fractional accumulation over ten cycles
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd4, 32'h1);
    rd_chk(3'd4, 32'h1, "R8 run bit set");
    repeat (8) @(negedge clk);
    wr_reg(3'd4, 32'h0);
    e64 = (64'd10 * 64'h0000_0001_9999_9999) >> 32;
    chk64("R2 ten fractional ticks", time_ns, e64);
    rd_chk(3'd0, e64[31:0], "R2 time lo after ticks");

    // R3 snapshot across a carry into the high word
    set_speed(2'd2);
    t0 = 64'h0000_0007_FFFF_FFF0;
    wr_reg(3'd0, t0[31:0]);
    wr_reg(3'd1, t0[63:32]);
    wr_reg(3'd4, 32'h1);
    rd_chk(3'd0, t0[31:0], "R3 snapshot lo");
    rd_chk(3'd1, t0[63:32], "R3 snapshot hi frozen");
    wr_reg(3'd4, 32'h0);
    e64 = t0 + 64'd96;
    chk64("R2 three whole-ns ticks", time_ns, e64);
    rd_chk(3'd0, e64[31:0], "R3 later lo");
    rd_chk(3'd1, e64[63:32], "R3 later hi");

    // R8 no advance with run bit clear
    repeat (5) @(negedge clk);
    chk64("R8 halted time stable", time_ns, e64);

    // R7 unsupported speed stops clock
    set_speed(2'd3);
    rd_chk(3'd2, 32'h0, "R7 zero inc lo");
    rd_chk(3'd3, 32'h0, "R7 zero inc hi");
    wr_reg(3'd4, 32'h1);
    repeat (5) @(negedge clk);
    chk64("R7 clock stopped", time_ns, e64);
    wr_reg(3'd4, 32'h0);

    // R4 load wins over advance while running
    set_speed(2'd2);
    wr_reg(3'd4, 32'h1);
    wr_reg(3'd0, 32'h100);
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd4, 32'h0);
    chk64("R4 load then one tick", time_ns, 64'h120);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule